// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block takes 86 interrupt request lines and decides which one the processor core should service next. Each line has a two-bit priority level, 0 to 3, where 3 is the most urgent, and its own enable. The core supplies a two-bit interrupt mask. The mask sets the lowest level that may still interrupt, and this is what lets a more urgent request nest on top of the handler currently running. Among the permitted pending requests, the highest level wins. Within that level, the lowest line number wins.

The block registers the decision. One clock after the inputs are seen, it presents a request flag to the core, the 7-bit vector number of the winner and a vector address. The address is the programmable base with the vector number concatenated below it, so each line gets its own slot in the vector table.

Software programs the block through a plain write port. Address 0 holds the vector base. Address 1+i holds the configuration of line i. A small number of low-numbered lines have a fixed level that writes cannot change.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is applied, and until the first decision after reset, the request flag is 0, the vector number is 0 and the vector address is 0. Reset clears every enable, every programmable level and the base.
- R2: The request flag rises in the clock after an enabled line is pending at a permitted level. It falls in the clock after no such line remains.
- R3: For mask value m (0 to 3), only lines whose level is at least m are permitted: mask 0 admits levels 0–3 and mask 3 admits only level 3.
- R4: When permitted requests are pending at several levels, the winner comes from the highest level, whatever the line numbers.
- R5: Within the winning level, the pending line with the lowest number wins.
- R6: The vector address equals base × 128 plus the vector number. When no request is flagged, the vector number is 0.
- R7: A write to address 0 loads the base from write-data bits 8:0. A write to address 1+i loads line i: level from bits 1:0 and enable from bit 2. The new setting governs the decision made on the following clock.
- R8: A line whose enable is 0 never causes a request, at any level or mask.
- R9: Lines 0 and 1 always sit at level 3. Writes change their enable, but the level bits of those writes are ignored.
- R10: Writes to addresses above 86 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 86 | Level-sensitive request lines, bit i is line i |
| core_mask | input | 2 | Core interrupt mask, lowest level allowed to interrupt |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration write address |
| cfg_wdata | input | 9 | Configuration write data |
| irq_to_core | output | 1 | Registered request to the core |
| vec_num | output | 7 | Registered winning line number |
| vec_addr | output | 16 | Registered vector address |

## Verification
The bound checker verifies every cycle that a flagged winner was pending, enabled and permitted one clock earlier. It also checks that a pending fixed-level line forces the winner to level 3, and that the low address bits match the vector number with a zero vector when idle. Arbitration order itself is shown only by the bench's reference model and its directed scenarios: highest level first, then lowest index, under each mask value. The same holds for write timing, ignored writes to fixed levels and unused addresses, and the one-cycle rise and fall of the request flag.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVL - 1);
  localparam int CFG_LVL_LSB = 0;
  localparam int CFG_EN_BIT  = 2;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs import irq_pkg::*; #(
  parameter int NUM_SRC   = 86,
  parameter int NUM_FIXED = 2,
  parameter int BASE_W    = 9,
  parameter int ADDR_W    = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [BASE_W-1:0]       cfg_wdata,
  output logic [BASE_W-1:0]       base,
  output logic [NUM_SRC-1:0]      src_en,
  output lvl_t [NUM_SRC-1:0]      src_lvl
);
  logic              base_we;
  logic [BASE_W-1:0] base_q;

  assign base_we = cfg_we && (cfg_addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= cfg_wdata;
  end
  assign base = base_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic src_we;
    logic en_q;
    assign src_we = cfg_we && (cfg_addr == ADDR_W'(i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (src_we) en_q <= cfg_wdata[CFG_EN_BIT];
    end
    assign src_en[i] = en_q;

    if (i < NUM_FIXED) begin : g_fixed
      assign src_lvl[i] = TOP_LVL;
    end else begin : g_prog
      lvl_t lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lvl_q <= '0;
        else if (src_we) lvl_q <= cfg_wdata[CFG_LVL_LSB +: LVL_W];
      end
      assign src_lvl[i] = lvl_q;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 86,
  parameter int IDX_W = 7
) (
  input  logic [N-1:0]     act,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import irq_pkg::*; #(
  parameter int NUM_SRC   = 86,
  parameter int NUM_FIXED = 2,
  parameter int VEC_W     = 7,
  parameter int BASE_W    = 9,
  parameter int ADDR_W    = $clog2(NUM_SRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_req,
  input  logic [LVL_W-1:0]          core_mask,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [BASE_W-1:0]         cfg_wdata,
  output logic                      irq_to_core,
  output logic [VEC_W-1:0]          vec_num,
  output logic [BASE_W+VEC_W-1:0]   vec_addr
);
  localparam int VA_W = BASE_W + VEC_W;

  logic                   rst_sync_n;
  logic [BASE_W-1:0]      base;
  logic [NUM_SRC-1:0]     src_en;
  lvl_t [NUM_SRC-1:0]     src_lvl;
  logic [NUM_LVL-1:0]     lvl_found;
  logic [VEC_W-1:0]       lvl_idx [NUM_LVL];

  logic                   irq_d, irq_q;
  logic [VEC_W-1:0]       vec_d, vec_q;
  logic [VA_W-1:0]        addr_d, addr_q;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_cfg_regs #(
    .NUM_SRC   (NUM_SRC),
    .NUM_FIXED (NUM_FIXED),
    .BASE_W    (BASE_W),
    .ADDR_W    (ADDR_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .base      (base),
    .src_en    (src_en),
    .src_lvl   (src_lvl)
  );

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic             permit;
    logic [NUM_SRC-1:0] act;
    assign permit = (LVL_W'(l) >= core_mask);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      assign act[i] = permit && irq_req[i] && src_en[i] && (src_lvl[i] == LVL_W'(l));
    end
    irq_prio_enc #(.N(NUM_SRC), .IDX_W(VEC_W)) u_enc (
      .act   (act),
      .found (lvl_found[l]),
      .idx   (lvl_idx[l])
    );
  end

  always_comb begin
    irq_d = 1'b0;
    vec_d = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_found[l]) begin
        irq_d = 1'b1;
        vec_d = lvl_idx[l];
      end
    end
    addr_d = {base, vec_d};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      addr_q <= '0;
    end else begin
      irq_q  <= irq_d;
      vec_q  <= vec_d;
      addr_q <= addr_d;
    end
  end

  assign irq_to_core = irq_q;
  assign vec_num     = vec_q;
  assign vec_addr    = addr_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk import irq_pkg::*; #(
  parameter int NUM_SRC   = 86,
  parameter int NUM_FIXED = 2,
  parameter int VEC_W     = 7,
  parameter int BASE_W    = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_SRC-1:0]      irq_req,
  input logic [LVL_W-1:0]        core_mask,
  input logic [NUM_SRC-1:0]      src_en,
  input lvl_t [NUM_SRC-1:0]      src_lvl,
  input logic                    irq_to_core,
  input logic [VEC_W-1:0]        vec_num,
  input logic [BASE_W+VEC_W-1:0] vec_addr
);
  logic [NUM_SRC-1:0] req_d, en_d, fixed_mask;
  lvl_t [NUM_SRC-1:0] lvl_d;
  lvl_t               mask_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_fm
    assign fixed_mask[i] = (i < NUM_FIXED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d  <= '0;
      en_d   <= '0;
      lvl_d  <= '0;
      mask_d <= '0;
    end else begin
      req_d  <= irq_req;
      en_d   <= src_en;
      lvl_d  <= src_lvl;
      mask_d <= core_mask;
    end
  end

  p_win_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_to_core |-> (req_d[vec_num] && en_d[vec_num]));

  p_win_permitted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_to_core |-> (lvl_d[vec_num] >= mask_d));

  p_fixed_forces_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_d & en_d & fixed_mask)) && irq_to_core |-> (lvl_d[vec_num] == TOP_LVL));

  p_addr_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr[VEC_W-1:0] == vec_num);

  p_idle_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_to_core |-> (vec_num == '0));

  p_flag_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_to_core |-> (|req_d));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_SRC   (NUM_SRC),
  .NUM_FIXED (NUM_FIXED),
  .VEC_W     (VEC_W),
  .BASE_W    (BASE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_req     (irq_req),
  .core_mask   (core_mask),
  .src_en      (src_en),
  .src_lvl     (src_lvl),
  .irq_to_core (irq_to_core),
  .vec_num     (vec_num),
  .vec_addr    (vec_addr)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  localparam int NS = 86;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] irq_req;
  logic [1:0]    core_mask;
  logic          cfg_we;
  logic [6:0]    cfg_addr;
  logic [8:0]    cfg_wdata;
  logic          irq_to_core;
  logic [6:0]    vec_num;
  logic [15:0]   vec_addr;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R1";
  bit cmp_on = 1'b0;

  // reference model state
  int m_lvl [NS];
  bit m_en  [NS];
  int m_base;
  bit e_irq;
  int e_vec, e_addr;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .core_mask(core_mask),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq_to_core(irq_to_core), .vec_num(vec_num), .vec_addr(vec_addr)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        m_lvl[i] = (i < 2) ? 3 : 0;
        m_en[i]  = 1'b0;
      end
      m_base = 0; e_irq = 1'b0; e_vec = 0; e_addr = 0;
    end else begin
      bit hit;
      hit = 1'b0;
      e_vec = 0;
      for (int l = 3; l >= 0; l--) begin
        if (!hit && l >= int'(core_mask)) begin
          for (int i = 0; i < NS; i++) begin
            if (!hit && irq_req[i] && m_en[i] && m_lvl[i] == l) begin
              hit = 1'b1;
              e_vec = i;
            end
          end
        end
      end
      e_irq  = hit;
      e_addr = m_base * 128 + e_vec;
      if (cfg_we) begin
        if (cfg_addr == 0) m_base = int'(cfg_wdata);
        else if (int'(cfg_addr) <= NS) begin
          m_en[cfg_addr - 1] = cfg_wdata[2];
          if (int'(cfg_addr) - 1 >= 2) m_lvl[cfg_addr - 1] = int'(cfg_wdata[1:0]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_cmp++;
      if (irq_to_core !== e_irq || int'(vec_num) != e_vec || int'(vec_addr) != e_addr) begin
        n_bad++;
        $display("FAIL %s: got irq=%0b vec=%0d addr=%0h, expected irq=%0b vec=%0d addr=%0h",
                 cur_tag, irq_to_core, vec_num, vec_addr, e_irq, e_vec, e_addr);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = 9'(d);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic set_src(int i, int lvl, bit en);
    wr(i + 1, (int'(en) << 2) | lvl);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; core_mask = 2'd0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    step(3);
    // R1: reset state
    chk("R1", int'(irq_to_core), 0);
    chk("R1", int'(vec_num), 0);
    chk("R1", int'(vec_addr), 0);
    rst_n = 1'b1;
    step(4);
    cmp_on = 1'b1;

    // R7: base and source programming
    cur_tag = "R7";
    wr(0, 9'h1A5);
    set_src(10, 2, 1'b1);
    irq_req[10] = 1'b1;
    step();
    chk("R7", int'(vec_addr), 16'h1A5 * 128 + 10);
    // R6: concatenation
    chk("R6", int'(vec_num), 10);

    // R2: request falls one cycle after lines drop
    cur_tag = "R2";
    irq_req = '0;
    step();
    chk("R2", int'(irq_to_core), 0);
    chk("R6", int'(vec_num), 0);
    irq_req[10] = 1'b1;
    step();
    chk("R2", int'(irq_to_core), 1);

    // R5: lowest index in a level
    cur_tag = "R5";
    irq_req = '0;
    set_src(20, 1, 1'b1); set_src(30, 1, 1'b1); set_src(15, 1, 1'b1);
    irq_req[20] = 1'b1; irq_req[30] = 1'b1; irq_req[15] = 1'b1;
    step();
    chk("R5", int'(vec_num), 15);
    irq_req[15] = 1'b0;
    step();
    chk("R5", int'(vec_num), 20);

    // R4: higher level beats lower index
    cur_tag = "R4";
    set_src(50, 3, 1'b1); set_src(5, 0, 1'b1);
    irq_req[50] = 1'b1; irq_req[5] = 1'b1;
    step();
    chk("R4", int'(vec_num), 50);
    irq_req[50] = 1'b0;
    step();
    chk("R4", int'(vec_num), 20);

    // R3: mask sweep, levels 0(5),1(20),2(10),3(50)
    cur_tag = "R3";
    irq_req = '0;
    irq_req[5] = 1'b1; irq_req[20] = 1'b1; irq_req[10] = 1'b1;
    for (int m = 0; m < 4; m++) begin
      core_mask = 2'(m);
      step();
      chk("R3", int'(irq_to_core), (m <= 2) ? 1 : 0);
    end
    core_mask = 2'd2; irq_req = '0; irq_req[20] = 1'b1;
    step();
    chk("R3", int'(irq_to_core), 0);
    core_mask = 2'd1;
    step();
    chk("R3", int'(irq_to_core), 1);
    core_mask = 2'd0;

    // R8: disabled line ignored
    cur_tag = "R8";
    irq_req = '0;
    set_src(40, 3, 1'b0);
    irq_req[40] = 1'b1;
    step(2);
    chk("R8", int'(irq_to_core), 0);
    set_src(20, 1, 1'b0);
    irq_req[20] = 1'b1;
    step(2);
    chk("R8", int'(irq_to_core), 0);

    // R9: fixed lines stay at level 3
    cur_tag = "R9";
    irq_req = '0;
    set_src(1, 0, 1'b1);
    core_mask = 2'd3;
    irq_req[1] = 1'b1;
    step();
    chk("R9", int'(vec_num), 1);
    chk("R9", int'(irq_to_core), 1);
    set_src(0, 1, 1'b1);
    irq_req[0] = 1'b1;
    step();
    chk("R9", int'(vec_num), 0);
    core_mask = 2'd0;

    // R10: out-of-range writes do nothing
    cur_tag = "R10";
    irq_req = '0; irq_req[50] = 1'b1;
    wr(87, 9'h000); wr(100, 9'h000); wr(127, 9'h000);
    step();
    chk("R10", int'(vec_num), 50);
    chk("R10", int'(vec_addr), 16'h1A5 * 128 + 50);

    // mixed traffic against the model
    cur_tag = "R4";
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < NS; i++) irq_req[i] = ($urandom_range(0, 9) == 0);
      core_mask = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) wr($urandom_range(0, 127), $urandom_range(0, 511));
      else step();
    end

    cmp_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule